// File: doc/BRIEF.md
# Cache Hit/Miss Profiler

This block models the tag side of a set-associative cache so that an address stream can be profiled without storing any block contents. Each incoming address is divided into a block offset (ignored), a set index and a tag. The tag is compared against every line of the selected set. The access is then reported as a hit, as a plain miss that fills an empty line, or as a miss that evicts the least recently used line of a full set.

Each line holds only a valid flag, a tag and a recency rank. The ranks within a set always form a permutation of 0 to WAYS-1, where 0 is the most recently touched line. Set count, way count, block size and counter width are parameters. The default is 32 sets of 32-byte blocks, one way each (direct-mapped, 1 KB). Three saturating counters accumulate hits, misses and evictions. A statistics-clear pulse zeroes the counters and leaves the cached tags in place.

Top module: `cache_profiler`

## Requirements
- R1: An address is split with the low OFF_BITS bits as block offset, the next SET_BITS bits as set index and the remaining upper bits as tag. Two addresses that differ only in offset bits always land on the same line.
- R2: Each accepted access (`req_valid` high at a rising edge) raises `res_valid` and exactly one of `res_hit` and `res_miss` after that same edge. A cycle without an accepted access leaves all four result flags low.
- R3: An access is a hit exactly when a valid line in its set holds its tag.
- R4: A miss in a set that still has an empty line fills one empty line and leaves `res_evict` low.
- R5: A miss in a set whose WAYS lines are all valid raises `res_evict` together with `res_miss`. It replaces the line touched longest ago.
- R6: Every hit and every fill makes the touched line the most recently used line of its set. This decides which line a later eviction removes.
- R7: `hit_cnt`, `miss_cnt` and `evict_cnt` each rise by one for every flagged hit, miss and eviction. The new values appear in the same cycle as the flags.
- R8: A counter that has reached 2^CNT_W-1 holds that value and does not wrap.
- R9: `stat_clr` zeroes all three counters after the edge. It overrides any increment from an access in the same cycle. That access is still looked up, flagged and recorded in the tags.
- R10: A synchronous reset invalidates every line, zeroes the counters and clears the result flags. After reset, any address misses.
- R11: `req_ready` is always high, so one access can be accepted every cycle with no gap between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stat_clr | input | 1 | Zeroes the three counters |
| req_valid | input | 1 | An address is presented this cycle |
| req_ready | output | 1 | Access can be accepted (always high) |
| req_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | A result is reported this cycle |
| res_hit | output | 1 | The reported access hit |
| res_miss | output | 1 | The reported access missed |
| res_evict | output | 1 | The reported miss evicted a valid line |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |
| evict_cnt | output | CNT_W | Saturating eviction count |

## Verification
Every result is due one register stage after its request. The flags and the three counters for an access accepted at a rising edge are all valid once that edge has passed, and a clear or reset also takes effect at that same edge. The bench drives each new request at a falling edge. At the next falling edge it first compares the outputs with the values its own model predicted for the previous request, then drives the following request, so accesses stay back to back and each comparison lands exactly one edge after its stimulus. The model is a timestamp-based LRU over a 4-set, 2-way, 4-byte-block configuration with 6-bit counters. This size lets a full address sweep exercise fills, evictions and saturation.

// File: rtl/cprof_pkg.sv
package cprof_pkg;

  // Classification of one accepted access
  typedef enum logic [1:0] {
    OUTC_IDLE  = 2'd0,
    OUTC_HIT   = 2'd1,
    OUTC_FILL  = 2'd2,
    OUTC_EVICT = 2'd3
  } outcome_e;

  function automatic outcome_e classify(input logic fire, input logic hit,
                                        input logic full);
    if (!fire)     return OUTC_IDLE;
    else if (hit)  return OUTC_HIT;
    else if (full) return OUTC_EVICT;
    else           return OUTC_FILL;
  endfunction

endpackage

// File: rtl/cprof_way_match.sv
module cprof_way_match #(
  parameter int WAYS  = 1,
  parameter int TAG_W = 22,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       any_hit,
  output logic [WAY_W-1:0]           hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_valid[w] && (row_tag[w] == look_tag);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/cprof_victim_pick.sv
module cprof_victim_pick #(
  parameter int WAYS  = 1,
  parameter int AGE_W = 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][AGE_W-1:0] row_age,
  output logic                       set_full,
  output logic [WAY_W-1:0]           fill_way,
  output logic [WAY_W-1:0]           lru_way
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  assign set_full = &row_valid;

  // lowest-numbered empty way
  always_comb begin
    fill_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_valid[w]) fill_way = WAY_W'(w);
    end
  end

  // way holding the oldest rank
  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (row_age[w] == OLDEST) lru_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/cprof_sat_counter.sv
module cprof_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= bump(cnt);
  end

endmodule

// File: rtl/cache_profiler.sv
module cache_profiler
  import cprof_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 5,
  parameter int OFF_BITS = 5,
  parameter int WAYS     = 1,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_evict,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [CNT_W-1:0]  evict_cnt
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W = WAY_W;

  // ---- address fields ----
  function automatic logic [SET_BITS-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_BITS +: SET_BITS];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // rank after a touch: touched -> 0, younger than it -> one older
  function automatic logic [AGE_W-1:0] age_next(input logic [AGE_W-1:0] old_age,
                                                input logic [AGE_W-1:0] ref_age,
                                                input logic touched);
    if (touched)              return '0;
    else if (old_age < ref_age) return old_age + 1'b1;
    else                      return old_age;
  endfunction

  // ---- tag storage ----
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_q   [SETS];

  logic [SET_BITS-1:0]        lk_set;
  logic [TAG_W-1:0]           lk_tag;
  logic [WAYS-1:0]            row_valid;
  logic [WAYS-1:0][TAG_W-1:0] row_tag;
  logic [WAYS-1:0][AGE_W-1:0] row_age;

  assign lk_set    = addr_set(req_addr);
  assign lk_tag    = addr_tag(req_addr);
  assign row_valid = valid_q[lk_set];
  assign row_tag   = tag_q[lk_set];
  assign row_age   = age_q[lk_set];

  // ---- lookup ----
  logic [WAYS-1:0]  hit_vec;
  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  logic             set_full;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] lru_way;

  cprof_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .row_valid (row_valid),
    .row_tag   (row_tag),
    .look_tag  (lk_tag),
    .hit_vec   (hit_vec),
    .any_hit   (any_hit),
    .hit_way   (hit_way)
  );

  cprof_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
    .row_valid (row_valid),
    .row_age   (row_age),
    .set_full  (set_full),
    .fill_way  (fill_way),
    .lru_way   (lru_way)
  );

  // ---- named events ----
  logic       acc_fire;
  outcome_e   outc;
  logic       ev_hit, ev_miss, ev_evict;
  logic [WAY_W-1:0] tgt_way;
  logic [AGE_W-1:0] tgt_age;

  assign req_ready = 1'b1;
  assign acc_fire  = req_valid && req_ready;
  assign outc      = classify(acc_fire, any_hit, set_full);
  assign ev_hit    = (outc == OUTC_HIT);
  assign ev_evict  = (outc == OUTC_EVICT);
  assign ev_miss   = (outc == OUTC_FILL) || ev_evict;

  always_comb begin
    unique case (outc)
      OUTC_HIT:   tgt_way = hit_way;
      OUTC_EVICT: tgt_way = lru_way;
      default:    tgt_way = fill_way;
    endcase
  end

  assign tgt_age = row_age[tgt_way];

  // ---- state update ----
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          age_q[s][w]   <= AGE_W'(w);
        end
      end
    end else if (acc_fire) begin
      valid_q[lk_set][tgt_way] <= 1'b1;
      tag_q[lk_set][tgt_way]   <= lk_tag;
      for (int w = 0; w < WAYS; w++) begin
        age_q[lk_set][w] <= age_next(row_age[w], tgt_age, WAY_W'(w) == tgt_way);
      end
    end
  end

  // ---- registered result flags ----
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_evict <= 1'b0;
    end else begin
      res_valid <= acc_fire;
      res_hit   <= ev_hit;
      res_miss  <= ev_miss;
      res_evict <= ev_evict;
    end
  end

  // ---- statistics ----
  logic [2:0]            cnt_inc;
  logic [2:0][CNT_W-1:0] cnt_val;

  assign cnt_inc = {ev_evict, ev_miss, ev_hit};

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    cprof_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (stat_clr),
      .inc (cnt_inc[k]),
      .cnt (cnt_val[k])
    );
  end

  assign hit_cnt   = cnt_val[0];
  assign miss_cnt  = cnt_val[1];
  assign evict_cnt = cnt_val[2];

endmodule

// File: rtl/cprof_checker.sv
module cprof_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             stat_clr,
  input logic             acc_fire,
  input logic             ev_hit,
  input logic             ev_miss,
  input logic             ev_evict,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss,
  input logic             res_evict,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] miss_cnt,
  input logic [CNT_W-1:0] evict_cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> res_valid);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_fire |=> !res_valid && !res_hit && !res_miss && !res_evict);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_hit, res_miss}) == 1);

  // R5
  evict_is_miss_chk: assert property (@(posedge clk) disable iff (rst)
    res_evict |-> res_miss);

  // R7
  hit_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_hit && !stat_clr && hit_cnt != TOP) |=> hit_cnt == $past(hit_cnt) + 1'b1);

  // R7
  miss_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_miss && !stat_clr && miss_cnt != TOP) |=> miss_cnt == $past(miss_cnt) + 1'b1);

  // R7
  evict_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_evict && !stat_clr && evict_cnt != TOP) |=> evict_cnt == $past(evict_cnt) + 1'b1);

  // R8
  hit_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_cnt == TOP && !stat_clr) |=> hit_cnt == TOP);

  // R8
  miss_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == TOP && !stat_clr) |=> miss_cnt == TOP);

  // R9
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (hit_cnt == '0) && (miss_cnt == '0) && (evict_cnt == '0));

endmodule

bind cache_profiler cprof_checker #(.CNT_W(CNT_W)) u_cprof_checker (
  .clk       (clk),
  .rst       (rst),
  .stat_clr  (stat_clr),
  .acc_fire  (acc_fire),
  .ev_hit    (ev_hit),
  .ev_miss   (ev_miss),
  .ev_evict  (ev_evict),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_miss  (res_miss),
  .res_evict (res_evict),
  .hit_cnt   (hit_cnt),
  .miss_cnt  (miss_cnt),
  .evict_cnt (evict_cnt)
);

// File: tb/cache_profiler_bench.sv
`timescale 1ns/1ps
module cache_profiler_bench;

  localparam int ADDR_W   = 8;
  localparam int SET_BITS = 2;
  localparam int OFF_BITS = 2;
  localparam int WAYS     = 2;
  localparam int CNT_W    = 6;
  localparam int NSETS    = 4;
  localparam int CMAX     = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_clr = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, res_valid, res_hit, res_miss, res_evict;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, evict_cnt;

  always #2 clk = ~clk;

  cache_profiler #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS),
    .WAYS(WAYS), .CNT_W(CNT_W)
  ) u_cache_profiler (
    .clk(clk), .rst(rst), .stat_clr(stat_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_evict(res_evict), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
    .evict_cnt(evict_cnt)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model: last-use timestamps per line
  bit m_valid [NSETS][WAYS];
  int m_tag   [NSETS][WAYS];
  int m_time  [NSETS][WAYS];
  int clock_now = 0;
  int m_hits = 0, m_miss = 0, m_evs = 0;

  // expectations for the previous step
  logic [4:0] exp_flags = 5'b10000;
  int    exp_h = 0, exp_m = 0, exp_e = 0;
  string exp_tag = "R10";

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0;
        m_time[s][w]  = 0;
      end
    m_hits = 0; m_miss = 0; m_evs = 0;
  endtask

  // returns {hit, miss, evict}
  task automatic model_access(input int a, output logic [2:0] res);
    int s, t, way;
    s = (a >> OFF_BITS) % NSETS;
    t = a >> (OFF_BITS + SET_BITS);
    clock_now++;
    way = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == t) way = w;
    if (way >= 0) begin
      res = 3'b100;
      m_hits = sat_inc(m_hits);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!m_valid[s][w]) way = w;
      if (way >= 0) begin
        res = 3'b010;
      end else begin
        way = 0;
        for (int w = 1; w < WAYS; w++)
          if (m_time[s][w] < m_time[s][way]) way = w;
        res = 3'b011;
        m_evs = sat_inc(m_evs);
      end
      m_miss = sat_inc(m_miss);
      m_valid[s][way] = 1;
      m_tag[s][way] = t;
    end
    m_time[s][way] = clock_now;
  endtask

  // check previous step's outcome, then drive a new one
  task automatic step(input bit v, input int a, input bit clr, input bit r, input string tag);
    logic [2:0] res;
    @(negedge clk);
    check(exp_tag, "ready,valid,hit,miss,evict",
          int'({req_ready, res_valid, res_hit, res_miss, res_evict}), int'(exp_flags));
    check(exp_tag, "hit_cnt",   int'(hit_cnt),   exp_h);
    check(exp_tag, "miss_cnt",  int'(miss_cnt),  exp_m);
    check(exp_tag, "evict_cnt", int'(evict_cnt), exp_e);
    rst = r; stat_clr = clr; req_valid = v; req_addr = ADDR_W'(a);
    if (r) begin
      model_reset();
      exp_flags = 5'b10000;
    end else begin
      res = 3'b000;
      if (v) model_access(a, res);
      if (clr) begin m_hits = 0; m_miss = 0; m_evs = 0; end
      exp_flags = {1'b1, v, res};
    end
    exp_h = m_hits; exp_m = m_miss; exp_e = m_evs;
    exp_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int a;
    model_reset();
    // R10: reset state
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R2");

    // R1 / R11: full back-to-back sweep over all addresses, offsets ignored
    for (int i = 0; i < 256; i++) step(1, i, 0, 0, "R1");
    // R8: counters sit at saturation after the sweep
    for (int i = 0; i < 80; i++) step(1, i * 4, 0, 0, "R8");

    // R9: clear together with an access
    step(1, 8'h55, 1, 0, "R9");
    step(1, 8'h55, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, "R2");

    // R4 / R6 / R5: LRU order inside set 0
    step(0, 0, 0, 1, "R10");
    step(1, 8'h10, 0, 0, "R4");
    step(1, 8'h21, 0, 0, "R4");
    step(1, 8'h13, 0, 0, "R3");
    step(1, 8'h30, 0, 0, "R5");
    step(1, 8'h12, 0, 0, "R6");
    step(1, 8'h20, 0, 0, "R6");
    step(1, 8'h31, 0, 0, "R6");
    step(1, 8'h22, 0, 0, "R6");
    step(0, 0, 0, 0, "R2");

    // R10: reset mid-run invalidates lines
    step(1, 8'h10, 0, 0, "R3");
    step(0, 0, 0, 1, "R10");
    step(1, 8'h10, 0, 0, "R10");

    // R3 / R7 / R11: pseudo-random stream with gaps and clears
    seed = 7;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 16) & 8'hFF;
      if (i % 3 == 0) a = a & 8'h3F;
      step(((seed >>> 8) & 7) != 0, a, (i % 700) == 699, 0, "R7");
    end
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule